// File: doc/BRIEF.md
# Coherence Message Event Classifier

This block sits between three incoming message queues of a shared cache bank and the line controller that runs the coherence transitions. Each cycle it is idle, it looks at the heads of the unblock queue, the response queue and the request queue. It takes the highest-priority head that is ready and turns it into a single controller event. The event depends on the message type and the sender class. For requests, it also depends on the addressed line's tag-lookup result (valid bit and sharer vector) and on whether the set still has a free way. The lookup results, the victim's dirty bit and the victim address are inputs. The queues themselves live outside.

When a request misses and the set has no free way, the block does not pass the request on. It emits a dirty or clean replacement event against the victim line, and leaves the request at the head of its queue, so the request is classified again once room exists. A message whose type code is not defined is popped and discarded, and a sticky error flag is raised. Events leave through a valid/ready handshake. The source queue is popped in the cycle the controller accepts the event.

The control is a two-state machine. `ST_SCAN` samples the queue heads. It moves to `ST_OFFER` on a decodable message (event registered). It stays in `ST_SCAN` on an undefined type (message dropped, error set) or when no queue is ready. `ST_OFFER` holds the event. It returns to `ST_SCAN` on `evt_ready`, popping the recorded source, and stays in `ST_OFFER` while `evt_ready` is low.

Top module: `coh_event_classifier`

## Requirements
- R1: The unblock queue wins over the response queue, and the response queue wins over the request queue. Exactly the winner's event is emitted, and only the winner's queue is popped.
- R2: An unblock message of type 0 yields UNBLOCK (code 0), and type 1 yields EXCL_UNBLOCK (code 1).
- R3: A response from a first-level cache (`rsp_from_l1`=1) of type 0 (data) yields WB_DIRTY (code 2) when `rsp_dirty` is 1, and WB_CLEAN (code 3) otherwise.
- R4: A first-level response of type 1 (ack) yields ACK_FINAL (code 5) when `pend_acks - rsp_ack_cnt` is zero modulo 2^CNT_W. Otherwise it yields ACK_PART (code 4).
- R5: A memory response (`rsp_from_l1`=0) of type 0, 1 or 2 yields MEM_DATA (6), MEM_ACK (7) or MEM_INV (8) respectively.
- R6: Request types 0, 1 and 2 yield RD_SHARED (9), RD_INSTR (10) and RD_EXCL (11) respectively.
- R7: A request of type 3 (upgrade) yields UPGRADE (12) only when `line_valid` is 1 and `line_sharers[req_id]` is 1. Otherwise it yields RD_EXCL (11).
- R8: A request of type 4 (writeback) yields WB_CURRENT (13) when `line_valid` is 1 and `line_sharers[req_id]` is 1. Otherwise it yields WB_STALE (14).
- R9: A defined request with `line_valid`=0 and `way_free`=0 yields REPL_DIRTY (15) if `victim_dirty` is 1, or REPL_CLEAN (16) otherwise. The event carries `victim_addr`, and no queue is popped on acceptance.
- R10: An undefined type pops its queue in the scan cycle and emits no event. Undefined types are unblock 2–3, L1 response 2–3, memory response 3, and request 5–7. `err_sticky` is set and stays set until reset.
- R11: An offered event keeps `evt_valid`, `evt_code` and `evt_addr` stable until `evt_ready`. The source queue is popped only in the accept cycle, and at most one pop is active per cycle.
- R12: After reset, `evt_valid`, all pops and `err_sticky` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ub_valid | input | 1 | Unblock queue head present |
| ub_type | input | 2 | Unblock type code |
| ub_addr | input | ADDR_W | Unblock line address |
| ub_pop | output | 1 | Pop unblock queue |
| rsp_valid | input | 1 | Response queue head present |
| rsp_type | input | 2 | Response type code |
| rsp_from_l1 | input | 1 | 1: sender is a first-level cache, 0: memory |
| rsp_dirty | input | 1 | Dirty flag of a data response |
| rsp_ack_cnt | input | CNT_W | Ack count carried by the response |
| rsp_addr | input | ADDR_W | Response line address |
| pend_acks | input | CNT_W | Pending ack count of the line's transaction |
| rsp_pop | output | 1 | Pop response queue |
| req_valid | input | 1 | Request queue head present |
| req_type | input | 3 | Request type code |
| req_id | input | ID_W | Requesting first-level cache index |
| req_addr | input | ADDR_W | Request line address |
| req_pop | output | 1 | Pop request queue |
| line_valid | input | 1 | Request line hit in the tag array |
| line_sharers | input | NUM_L1 | Sharer vector of the request line |
| way_free | input | 1 | Set of the request line has a free way |
| victim_dirty | input | 1 | Dirty bit of the chosen victim |
| victim_addr | input | ADDR_W | Address of the chosen victim |
| evt_valid | output | 1 | Event offered |
| evt_ready | input | 1 | Controller accepts the event |
| evt_code | output | 5 | Event code |
| evt_addr | output | ADDR_W | Address the event applies to |
| err_sticky | output | 1 | An undefined message type was seen |

## Verification
Two functions collide when heads of all three queues are ready in the same scan cycle. Arbitration must then choose one of them, and the chosen message must still be classified correctly. The bench provokes this by presenting unblock, response and request heads together, then response and request together. It judges the result by the emitted code and address and by which single pop fires on acceptance. A second collision pairs a replacement with the still-pending request. The bench keeps the request queued across the replacement, frees a way, and expects the same request to come out as an ordinary read.

// File: rtl/coh_evt_pkg.sv
package coh_evt_pkg;

    typedef enum logic [4:0] {
        EV_UNBLOCK      = 5'd0,
        EV_EXCL_UNBLOCK = 5'd1,
        EV_WB_DIRTY     = 5'd2,
        EV_WB_CLEAN     = 5'd3,
        EV_ACK_PART     = 5'd4,
        EV_ACK_FINAL    = 5'd5,
        EV_MEM_DATA     = 5'd6,
        EV_MEM_ACK      = 5'd7,
        EV_MEM_INV      = 5'd8,
        EV_RD_SHARED    = 5'd9,
        EV_RD_INSTR     = 5'd10,
        EV_RD_EXCL      = 5'd11,
        EV_UPGRADE      = 5'd12,
        EV_WB_CURRENT   = 5'd13,
        EV_WB_STALE     = 5'd14,
        EV_REPL_DIRTY   = 5'd15,
        EV_REPL_CLEAN   = 5'd16
    } evt_e;

    // source index into the arbitration vector, lowest wins
    localparam int SRC_UB  = 0;
    localparam int SRC_RSP = 1;
    localparam int SRC_REQ = 2;
    localparam int NUM_SRC = 3;

    typedef struct packed {
        logic ok;
        evt_e ev;
    } dec_t;

endpackage

// File: rtl/coh_evt_arb.sv
module coh_evt_arb #(
    parameter int N = 3
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);
    logic [N:0] seen;

    assign seen[0] = 1'b0;

    generate
        for (genvar i = 0; i < N; i++) begin : g_slot
            assign gnt[i]    = req[i] & ~seen[i];
            assign seen[i+1] = seen[i] | req[i];
        end
    endgenerate
endmodule

// File: rtl/coh_evt_resp_dec.sv
module coh_evt_resp_dec
    import coh_evt_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic [1:0]       ub_type,
    input  logic [1:0]       rsp_type,
    input  logic             rsp_from_l1,
    input  logic             rsp_dirty,
    input  logic [CNT_W-1:0] rsp_ack_cnt,
    input  logic [CNT_W-1:0] pend_acks,
    output dec_t             ub_dec,
    output dec_t             rsp_dec
);
    logic [CNT_W-1:0] acks_left;

    assign acks_left = pend_acks - rsp_ack_cnt;

    always_comb begin
        ub_dec = '{ok: 1'b0, ev: EV_UNBLOCK};
        unique case (ub_type)
            2'd0:    ub_dec = '{ok: 1'b1, ev: EV_UNBLOCK};
            2'd1:    ub_dec = '{ok: 1'b1, ev: EV_EXCL_UNBLOCK};
            default: ub_dec = '{ok: 1'b0, ev: EV_UNBLOCK};
        endcase
    end

    always_comb begin
        rsp_dec = '{ok: 1'b0, ev: EV_MEM_DATA};
        if (rsp_from_l1) begin
            unique case (rsp_type)
                2'd0:    rsp_dec = '{ok: 1'b1, ev: rsp_dirty ? EV_WB_DIRTY : EV_WB_CLEAN};
                2'd1:    rsp_dec = '{ok: 1'b1,
                                     ev: (acks_left == '0) ? EV_ACK_FINAL : EV_ACK_PART};
                default: rsp_dec = '{ok: 1'b0, ev: EV_MEM_DATA};
            endcase
        end else begin
            unique case (rsp_type)
                2'd0:    rsp_dec = '{ok: 1'b1, ev: EV_MEM_DATA};
                2'd1:    rsp_dec = '{ok: 1'b1, ev: EV_MEM_ACK};
                2'd2:    rsp_dec = '{ok: 1'b1, ev: EV_MEM_INV};
                default: rsp_dec = '{ok: 1'b0, ev: EV_MEM_DATA};
            endcase
        end
    end
endmodule

// File: rtl/coh_evt_req_dec.sv
module coh_evt_req_dec
    import coh_evt_pkg::*;
#(
    parameter int NUM_L1 = 4,
    localparam int ID_W  = (NUM_L1 > 1) ? $clog2(NUM_L1) : 1
) (
    input  logic [2:0]        req_type,
    input  logic [ID_W-1:0]   req_id,
    input  logic              line_valid,
    input  logic [NUM_L1-1:0] line_sharers,
    input  logic              way_free,
    input  logic              victim_dirty,
    output dec_t              req_dec,
    output logic              req_evict
);
    logic is_sharer;
    evt_e base_ev;
    logic type_ok;

    assign is_sharer = line_valid & line_sharers[req_id];

    always_comb begin
        type_ok = 1'b1;
        base_ev = EV_RD_SHARED;
        unique case (req_type)
            3'd0:    base_ev = EV_RD_SHARED;
            3'd1:    base_ev = EV_RD_INSTR;
            3'd2:    base_ev = EV_RD_EXCL;
            3'd3:    base_ev = is_sharer ? EV_UPGRADE : EV_RD_EXCL;
            3'd4:    base_ev = is_sharer ? EV_WB_CURRENT : EV_WB_STALE;
            default: type_ok = 1'b0;
        endcase
    end

    assign req_evict = type_ok & ~line_valid & ~way_free;

    always_comb begin
        req_dec.ok = type_ok;
        if (req_evict) begin
            req_dec.ev = victim_dirty ? EV_REPL_DIRTY : EV_REPL_CLEAN;
        end else begin
            req_dec.ev = base_ev;
        end
    end
endmodule

// File: rtl/coh_event_classifier.sv
module coh_event_classifier
    import coh_evt_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int NUM_L1 = 4,
    parameter int CNT_W  = 4,
    localparam int ID_W  = (NUM_L1 > 1) ? $clog2(NUM_L1) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ub_valid,
    input  logic [1:0]        ub_type,
    input  logic [ADDR_W-1:0] ub_addr,
    output logic              ub_pop,
    input  logic              rsp_valid,
    input  logic [1:0]        rsp_type,
    input  logic              rsp_from_l1,
    input  logic              rsp_dirty,
    input  logic [CNT_W-1:0]  rsp_ack_cnt,
    input  logic [ADDR_W-1:0] rsp_addr,
    input  logic [CNT_W-1:0]  pend_acks,
    output logic              rsp_pop,
    input  logic              req_valid,
    input  logic [2:0]        req_type,
    input  logic [ID_W-1:0]   req_id,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_pop,
    input  logic              line_valid,
    input  logic [NUM_L1-1:0] line_sharers,
    input  logic              way_free,
    input  logic              victim_dirty,
    input  logic [ADDR_W-1:0] victim_addr,
    output logic              evt_valid,
    input  logic              evt_ready,
    output logic [4:0]        evt_code,
    output logic [ADDR_W-1:0] evt_addr,
    output logic              err_sticky
);
    typedef enum logic {ST_SCAN, ST_OFFER} st_e;

    st_e                state_q, state_d;
    logic [NUM_SRC-1:0] ready_vec, gnt;
    dec_t               ub_dec, rsp_dec, req_dec;
    logic               req_evict;

    dec_t               sel_dec;
    logic [ADDR_W-1:0]  sel_addr;
    logic [NUM_SRC-1:0] sel_pop;

    evt_e               code_q;
    logic [ADDR_W-1:0]  addr_q;
    logic [NUM_SRC-1:0] src_q;
    logic               err_q;

    logic               load_evt, drop_msg;
    logic [NUM_SRC-1:0] pop_vec;

    assign ready_vec[SRC_UB]  = ub_valid;
    assign ready_vec[SRC_RSP] = rsp_valid;
    assign ready_vec[SRC_REQ] = req_valid;

    coh_evt_arb #(.N(NUM_SRC)) u_arb (
        .req (ready_vec),
        .gnt (gnt)
    );

    coh_evt_resp_dec #(.CNT_W(CNT_W)) u_resp_dec (
        .ub_type     (ub_type),
        .rsp_type    (rsp_type),
        .rsp_from_l1 (rsp_from_l1),
        .rsp_dirty   (rsp_dirty),
        .rsp_ack_cnt (rsp_ack_cnt),
        .pend_acks   (pend_acks),
        .ub_dec      (ub_dec),
        .rsp_dec     (rsp_dec)
    );

    coh_evt_req_dec #(.NUM_L1(NUM_L1)) u_req_dec (
        .req_type     (req_type),
        .req_id       (req_id),
        .line_valid   (line_valid),
        .line_sharers (line_sharers),
        .way_free     (way_free),
        .victim_dirty (victim_dirty),
        .req_dec      (req_dec),
        .req_evict    (req_evict)
    );

    // select the granted head
    always_comb begin
        sel_dec  = '{ok: 1'b0, ev: EV_UNBLOCK};
        sel_addr = '0;
        sel_pop  = '0;
        if (gnt[SRC_UB]) begin
            sel_dec  = ub_dec;
            sel_addr = ub_addr;
            sel_pop  = NUM_SRC'(1) << SRC_UB;
        end else if (gnt[SRC_RSP]) begin
            sel_dec  = rsp_dec;
            sel_addr = rsp_addr;
            sel_pop  = NUM_SRC'(1) << SRC_RSP;
        end else if (gnt[SRC_REQ]) begin
            sel_dec  = req_dec;
            sel_addr = req_evict ? victim_addr : req_addr;
            sel_pop  = req_evict ? '0 : (NUM_SRC'(1) << SRC_REQ);
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_SCAN;
        end else begin
            state_q <= state_d;
        end
    end

    // next state, pops and load strobes
    always_comb begin
        state_d  = state_q;
        load_evt = 1'b0;
        drop_msg = 1'b0;
        pop_vec  = '0;
        unique case (state_q)
            ST_SCAN: begin
                if (|gnt) begin
                    if (sel_dec.ok) begin
                        load_evt = 1'b1;
                        state_d  = ST_OFFER;
                    end else begin
                        drop_msg = 1'b1;
                        pop_vec  = gnt;
                    end
                end
            end
            ST_OFFER: begin
                if (evt_ready) begin
                    pop_vec = src_q;
                    state_d = ST_SCAN;
                end
            end
            default: state_d = ST_SCAN;
        endcase
    end

    // event holding registers and sticky error
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code_q <= EV_UNBLOCK;
            addr_q <= '0;
            src_q  <= '0;
            err_q  <= 1'b0;
        end else begin
            if (load_evt) begin
                code_q <= sel_dec.ev;
                addr_q <= sel_addr;
                src_q  <= sel_pop;
            end
            if (drop_msg) begin
                err_q <= 1'b1;
            end
        end
    end

    assign evt_valid  = (state_q == ST_OFFER);
    assign evt_code   = code_q;
    assign evt_addr   = addr_q;
    assign err_sticky = err_q;
    assign ub_pop     = pop_vec[SRC_UB];
    assign rsp_pop    = pop_vec[SRC_RSP];
    assign req_pop    = pop_vec[SRC_REQ];
endmodule

// File: rtl/coh_evt_chk.sv
module coh_evt_chk
    import coh_evt_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ub_valid,
    input logic              ub_pop,
    input logic              rsp_pop,
    input logic              req_pop,
    input logic              evt_valid,
    input logic              evt_ready,
    input logic [4:0]        evt_code,
    input logic [ADDR_W-1:0] evt_addr,
    input logic              err_sticky
);
    p_single_pop_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ub_pop, rsp_pop, req_pop}));

    p_hold_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && !evt_ready) |=> (evt_valid && $stable(evt_code) && $stable(evt_addr)));

    p_repl_keeps_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_valid && (evt_code == EV_REPL_DIRTY || evt_code == EV_REPL_CLEAN)) |-> !req_pop);

    p_err_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        err_sticky |=> err_sticky);

    p_unblock_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(evt_valid) && $past(ub_valid)) |->
            (evt_code == EV_UNBLOCK || evt_code == EV_EXCL_UNBLOCK));
endmodule

bind coh_event_classifier coh_evt_chk #(.ADDR_W(ADDR_W)) u_coh_evt_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ub_valid   (ub_valid),
    .ub_pop     (ub_pop),
    .rsp_pop    (rsp_pop),
    .req_pop    (req_pop),
    .evt_valid  (evt_valid),
    .evt_ready  (evt_ready),
    .evt_code   (evt_code),
    .evt_addr   (evt_addr),
    .err_sticky (err_sticky)
);

// File: tb/test_coh_event_classifier.sv
module test_coh_event_classifier;
    localparam int ADDR_W = 16;
    localparam int NUM_L1 = 4;
    localparam int CNT_W  = 4;
    localparam int ID_W   = 2;

    localparam logic [ADDR_W-1:0] A_UB  = 16'h1100;
    localparam logic [ADDR_W-1:0] A_RSP = 16'h2200;
    localparam logic [ADDR_W-1:0] A_REQ = 16'h3300;
    localparam logic [ADDR_W-1:0] A_VIC = 16'h4400;

    typedef struct packed {
        logic       ubv;  logic [1:0] ubt;
        logic       rv;   logic [1:0] rt;  logic rl1; logic rd;
        logic [3:0] rc;   logic [3:0] pa;
        logic       qv;   logic [2:0] qt;  logic [1:0] qid;
        logic       lv;   logic [3:0] sh;  logic wf;  logic vd;
        logic [4:0] ev;   logic [2:0] pop;   // pop = {ub, rsp, req}
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{1,1, 1,0,1,1, 0,0, 1,0,0, 1,4'h1,1,0, 5'd1,  3'b100}, // R1 R2 all valid
        '{1,0, 0,0,0,0, 0,0, 0,0,0, 0,4'h0,1,0, 5'd0,  3'b100}, // R2
        '{0,0, 1,0,1,1, 0,0, 1,0,0, 1,4'h1,1,0, 5'd2,  3'b010}, // R1 R3
        '{0,0, 1,0,1,0, 0,0, 0,0,0, 0,4'h0,1,0, 5'd3,  3'b010}, // R3
        '{0,0, 1,1,1,0, 2,3, 0,0,0, 0,4'h0,1,0, 5'd4,  3'b010}, // R4 partial
        '{0,0, 1,1,1,0, 3,3, 0,0,0, 0,4'h0,1,0, 5'd5,  3'b010}, // R4 final
        '{0,0, 1,0,0,1, 0,0, 0,0,0, 0,4'h0,1,0, 5'd6,  3'b010}, // R5
        '{0,0, 1,1,0,0, 0,0, 0,0,0, 0,4'h0,1,0, 5'd7,  3'b010}, // R5
        '{0,0, 1,2,0,0, 0,0, 0,0,0, 0,4'h0,1,0, 5'd8,  3'b010}, // R5
        '{0,0, 0,0,0,0, 0,0, 1,0,2, 1,4'h0,1,0, 5'd9,  3'b001}, // R6
        '{0,0, 0,0,0,0, 0,0, 1,1,2, 1,4'h0,1,0, 5'd10, 3'b001}, // R6
        '{0,0, 0,0,0,0, 0,0, 1,2,2, 1,4'h0,1,0, 5'd11, 3'b001}, // R6
        '{0,0, 0,0,0,0, 0,0, 1,3,1, 1,4'h2,1,0, 5'd12, 3'b001}, // R7 sharer
        '{0,0, 0,0,0,0, 0,0, 1,3,1, 1,4'hD,1,0, 5'd11, 3'b001}, // R7 non-sharer
        '{0,0, 0,0,0,0, 0,0, 1,3,1, 0,4'h2,1,0, 5'd11, 3'b001}, // R7 invalid line
        '{0,0, 0,0,0,0, 0,0, 1,4,3, 1,4'h8,1,0, 5'd13, 3'b001}, // R8 current
        '{0,0, 0,0,0,0, 0,0, 1,4,3, 1,4'h7,1,0, 5'd14, 3'b001}, // R8 stale
        '{0,0, 0,0,0,0, 0,0, 1,0,0, 0,4'h0,0,1, 5'd15, 3'b000}, // R9 dirty victim
        '{0,0, 0,0,0,0, 0,0, 1,4,0, 0,4'h0,0,0, 5'd16, 3'b000}, // R9 clean victim
        '{0,0, 0,0,0,0, 0,0, 1,0,0, 0,4'h0,1,0, 5'd9,  3'b001}  // R9 miss with free way
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ub_valid = 0;  logic [1:0] ub_type = 0;
    logic              rsp_valid = 0; logic [1:0] rsp_type = 0;
    logic              rsp_from_l1 = 0, rsp_dirty = 0;
    logic [CNT_W-1:0]  rsp_ack_cnt = 0, pend_acks = 0;
    logic              req_valid = 0; logic [2:0] req_type = 0;
    logic [ID_W-1:0]   req_id = 0;
    logic              line_valid = 0; logic [NUM_L1-1:0] line_sharers = 0;
    logic              way_free = 1, victim_dirty = 0;
    logic              evt_ready = 0;
    logic              ub_pop, rsp_pop, req_pop, evt_valid, err_sticky;
    logic [4:0]        evt_code;
    logic [ADDR_W-1:0] evt_addr;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    coh_event_classifier #(.ADDR_W(ADDR_W), .NUM_L1(NUM_L1), .CNT_W(CNT_W)) i_coh_event_classifier (
        .clk(clk), .rst_n(rst_n),
        .ub_valid(ub_valid), .ub_type(ub_type), .ub_addr(A_UB), .ub_pop(ub_pop),
        .rsp_valid(rsp_valid), .rsp_type(rsp_type), .rsp_from_l1(rsp_from_l1),
        .rsp_dirty(rsp_dirty), .rsp_ack_cnt(rsp_ack_cnt), .rsp_addr(A_RSP),
        .pend_acks(pend_acks), .rsp_pop(rsp_pop),
        .req_valid(req_valid), .req_type(req_type), .req_id(req_id),
        .req_addr(A_REQ), .req_pop(req_pop),
        .line_valid(line_valid), .line_sharers(line_sharers), .way_free(way_free),
        .victim_dirty(victim_dirty), .victim_addr(A_VIC),
        .evt_valid(evt_valid), .evt_ready(evt_ready), .evt_code(evt_code),
        .evt_addr(evt_addr), .err_sticky(err_sticky)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string tag_of(input int ev);
        if (ev <= 1)  return "R2";
        if (ev <= 3)  return "R3";
        if (ev <= 5)  return "R4";
        if (ev <= 8)  return "R5";
        if (ev == 12) return "R7";
        if (ev <= 11) return "R6";
        if (ev <= 14) return "R8";
        return "R9";
    endfunction

    task automatic clear_inputs();
        ub_valid = 0; rsp_valid = 0; req_valid = 0;
        evt_ready = 0;
    endtask

    task automatic run_vec(input vec_t v, input string tag);
        int w;
        logic [ADDR_W-1:0] ea;
        @(negedge clk);
        ub_valid = v.ubv; ub_type = v.ubt;
        rsp_valid = v.rv; rsp_type = v.rt; rsp_from_l1 = v.rl1; rsp_dirty = v.rd;
        rsp_ack_cnt = v.rc; pend_acks = v.pa;
        req_valid = v.qv; req_type = v.qt; req_id = v.qid;
        line_valid = v.lv; line_sharers = v.sh; way_free = v.wf; victim_dirty = v.vd;
        evt_ready = 0;
        w = 0;
        do begin
            @(negedge clk);
            w++;
        end while (!evt_valid && w < 8);
        ea = v.pop[2] ? A_UB : v.pop[1] ? A_RSP : v.pop[0] ? A_REQ : A_VIC;
        chk(evt_valid === 1'b1, tag, "evt_valid", int'(evt_valid), 1);
        chk(evt_code === v.ev, tag, "evt_code", int'(evt_code), int'(v.ev));
        chk(evt_addr === ea, tag, "evt_addr", int'(evt_addr), int'(ea));
        evt_ready = 1;
        #1;
        chk({ub_pop, rsp_pop, req_pop} === v.pop, tag, "pops",
            int'({ub_pop, rsp_pop, req_pop}), int'(v.pop));
        @(negedge clk);
        clear_inputs();
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R12: reset state
        repeat (3) @(negedge clk);
        chk(evt_valid === 1'b0, "R12", "evt_valid", int'(evt_valid), 0);
        chk({ub_pop, rsp_pop, req_pop} === 3'b000, "R12", "pops",
            int'({ub_pop, rsp_pop, req_pop}), 0);
        chk(err_sticky === 1'b0, "R12", "err_sticky", int'(err_sticky), 0);
        rst_n = 1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            run_vec(VECS[i], (i == 0 || i == 2) ? "R1" : tag_of(int'(VECS[i].ev)));
        end

        // R9: request stays queued across replacement, then classified normally
        @(negedge clk);
        req_valid = 1; req_type = 3'd2; req_id = 0;
        line_valid = 0; way_free = 0; victim_dirty = 1;
        @(negedge clk);
        chk(evt_code === 5'd15, "R9", "repl code", int'(evt_code), 15);
        evt_ready = 1; #1;
        chk(req_pop === 1'b0, "R9", "req_pop on repl", int'(req_pop), 0);
        @(negedge clk);
        evt_ready = 0; way_free = 1;
        @(negedge clk); @(negedge clk);
        chk(evt_valid === 1'b1 && evt_code === 5'd11, "R9", "requeued code",
            int'(evt_code), 11);
        evt_ready = 1; #1;
        chk(req_pop === 1'b1, "R9", "req_pop after room", int'(req_pop), 1);
        @(negedge clk);
        clear_inputs();

        // R11: hold while not ready
        @(negedge clk);
        req_valid = 1; req_type = 3'd2; line_valid = 1; way_free = 1;
        @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            chk(evt_valid === 1'b1 && evt_code === 5'd11 && evt_addr === A_REQ,
                "R11", "held event", int'(evt_code), 11);
            chk(req_pop === 1'b0, "R11", "no pop before accept", int'(req_pop), 0);
            @(negedge clk);
        end
        evt_ready = 1; #1;
        chk(req_pop === 1'b1, "R11", "pop on accept", int'(req_pop), 1);
        @(negedge clk);
        clear_inputs();

        // R10: undefined unblock type is dropped
        @(negedge clk);
        ub_valid = 1; ub_type = 2'd2;
        #1;
        chk(ub_pop === 1'b1, "R10", "drop pop ub", int'(ub_pop), 1);
        @(negedge clk);
        ub_valid = 0;
        chk(err_sticky === 1'b1, "R10", "err_sticky", int'(err_sticky), 1);
        chk(evt_valid === 1'b0, "R10", "no event", int'(evt_valid), 0);
        // R10: undefined request type is dropped
        req_valid = 1; req_type = 3'd6; line_valid = 1;
        #1;
        chk(req_pop === 1'b1, "R10", "drop pop req", int'(req_pop), 1);
        @(negedge clk);
        req_valid = 0;
        @(negedge clk);
        chk(evt_valid === 1'b0, "R10", "no event req", int'(evt_valid), 0);
        // R10: error stays set across a normal event
        run_vec(VECS[1], "R10");
        chk(err_sticky === 1'b1, "R10", "err held", int'(err_sticky), 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule